// File: doc/BRIEF.md
# Reservation Flag Controller for Conditional Stores

This block holds one load-reserve/store-conditional reservation for a CPU that sits in front of an external bus. A load-reserve request from the CPU arms the reservation and records the word address it covers; a newer load-reserve replaces both. A cancel line from the outside world, active low and brought into the clock domain through a flop chain, clears the reservation when it is seen asserted.

When the CPU issues a store-conditional, the block decides its outcome before anything reaches the bus. With the reservation armed and the address matching, it starts the external write cycle and drives a reservation qualifier alongside the start strobe. Otherwise, no bus cycle is started and the CPU gets a failure status. Either way, the reservation is gone once the outcome is decided.

The CPU request port and the CPU response port are valid/ready streams. A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low while a store is on the bus or a response is waiting. A response is held, unchanged, until `rsp_ready` is seen high. On the bus side, `bus_start` and the address and data stay stable until `bus_ready` accepts them.

Top module: `resv_flag_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid`, `bus_start` and `bus_resv` are 0, and no reservation is held, so a store-conditional fails.
- R2: A load-reserve request (`req_kind`=0) arms the reservation at the edge that accepts it and is answered in the next cycle with `rsp_valid`=1, `rsp_ok`=1, with no bus cycle.
- R3: A store-conditional (`req_kind`=1) accepted while the reservation is armed for the same word address raises `bus_start` in the next cycle, carrying the request's address and data. Its response has `rsp_ok`=1 and is valid in the cycle after the edge where `bus_ready` is high.
- R4: A store-conditional accepted with no reservation held starts no bus cycle and is answered in the next cycle with `rsp_ok`=0.
- R5: A store-conditional whose word address differs from the reserved one fails as in R4.
- R6: Every accepted store-conditional, whether it succeeds or fails, clears the reservation, so a second store-conditional fails.
- R7: `cancel_n` is taken through a two-flop synchronizer. A low level held across one rising edge clears the reservation two edges later.
- R8: When a synchronized cancel and a load-reserve acceptance fall in the same cycle, the clear wins and no reservation is held afterwards.
- R9: A later load-reserve replaces the stored address. A store-conditional to the earlier address then fails, and one to the newer address succeeds.
- R10: Back-pressure: `req_ready` is 0 while `bus_start` or `rsp_valid` is 1. `bus_start` and `bus_addr` hold until `bus_ready`, and `rsp_valid` and `rsp_ok` hold until `rsp_ready`.
- R11: `bus_resv` is 1 in exactly the cycles in which `bus_start` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cancel_n | input | 1 | Asynchronous reservation cancel, active low |
| req_valid | input | 1 | CPU request valid |
| req_ready | output | 1 | CPU request ready |
| req_kind | input | 1 | 0 load-reserve, 1 store-conditional |
| req_addr | input | 30 | Word address of the request |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | CPU response valid |
| rsp_ready | input | 1 | CPU response ready |
| rsp_ok | output | 1 | 1 when the access succeeded |
| bus_start | output | 1 | External write cycle start strobe |
| bus_resv | output | 1 | Reservation qualifier, driven with the start strobe |
| bus_ready | input | 1 | Bus accepts the cycle |
| bus_addr | output | 30 | Bus word address |
| bus_wdata | output | 32 | Bus write data |

## Verification
The clear from the synchronized cancel line can land in the same cycle as the acceptance of a load-reserve. The bench provokes this by lowering `cancel_n` across exactly one edge and presenting the load-reserve so that it is accepted two edges later. It judges the result by a following store-conditional to the same address, which must fail with no bus strobe. A store-conditional acceptance, which also clears, is likewise checked against a reservation set just before it.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_RSP  = 2'd2
  } seq_state_e;

  localparam logic KIND_LOAD_RSV  = 1'b0;
  localparam logic KIND_STORE_CND = 1'b1;
endpackage

// File: rtl/resv_sync.sv
module resv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= async_n;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[s] <= 1'b1;
          else        chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/resv_flag_reg.sv
module resv_flag_reg #(
  parameter int ADDR_W = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic [ADDR_W-1:0] set_addr_i,
  input  logic              clr_i,
  output logic              flag_o,
  output logic [ADDR_W-1:0] addr_o
);
  // Clear has priority over set; the address follows every set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      addr_o <= '0;
    end else begin
      if (set_i) addr_o <= set_addr_i;
      if (clr_i)      flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
    end
  end
endmodule

// File: rtl/resv_seq.sv
module resv_seq
  import resv_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_ok,
  output logic              bus_start,
  output logic              bus_resv,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              flag_i,
  input  logic [ADDR_W-1:0] flag_addr_i,
  input  logic              cancel_i,
  output logic              lr_set_o,
  output logic              sc_take_o
);
  seq_state_e state_q;
  logic       ok_q;
  logic       resv_q;
  logic       accept;
  logic       hit;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign hit       = flag_i && !cancel_i && (flag_addr_i == req_addr);
  assign lr_set_o  = accept && (req_kind == KIND_LOAD_RSV);
  assign sc_take_o = accept && (req_kind == KIND_STORE_CND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ok_q      <= 1'b0;
      resv_q    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          bus_addr  <= req_addr;
          bus_wdata <= req_wdata;
          if (req_kind == KIND_LOAD_RSV) begin
            state_q <= ST_RSP;
            ok_q    <= 1'b1;
          end else if (hit) begin
            state_q <= ST_BUS;
            resv_q  <= 1'b1;
          end else begin
            state_q <= ST_RSP;
            ok_q    <= 1'b0;
          end
        end
        ST_BUS: if (bus_ready) begin
          state_q <= ST_RSP;
          ok_q    <= 1'b1;
          resv_q  <= 1'b0;
        end
        ST_RSP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_start = (state_q == ST_BUS);
  assign bus_resv  = resv_q;
  assign rsp_valid = (state_q == ST_RSP);
  assign rsp_ok    = ok_q;
endmodule

// File: rtl/resv_flag_ctrl.sv
module resv_flag_ctrl #(
  parameter int ADDR_W      = 30,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cancel_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_ok,
  output logic              bus_start,
  output logic              bus_resv,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata
);
  logic              cancel_sync_n;
  logic              cancel_act;
  logic              resv_flag;
  logic [ADDR_W-1:0] resv_addr;
  logic              lr_set;
  logic              sc_take;

  resv_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .async_n(cancel_n), .sync_n(cancel_sync_n)
  );

  assign cancel_act = !cancel_sync_n;

  resv_flag_reg #(.ADDR_W(ADDR_W)) i_flag (
    .clk(clk), .rst_n(rst_n),
    .set_i(lr_set), .set_addr_i(req_addr),
    .clr_i(cancel_act || sc_take),
    .flag_o(resv_flag), .addr_o(resv_addr)
  );

  resv_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ok(rsp_ok),
    .bus_start(bus_start), .bus_resv(bus_resv), .bus_ready(bus_ready),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .flag_i(resv_flag), .flag_addr_i(resv_addr), .cancel_i(cancel_act),
    .lr_set_o(lr_set), .sc_take_o(sc_take)
  );
endmodule

// File: rtl/resv_flag_ctrl_chk.sv
module resv_flag_ctrl_chk #(
  parameter int ADDR_W = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_ok,
  input logic              bus_start,
  input logic              bus_resv,
  input logic              bus_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              resv_flag,
  input logic              cancel_act,
  input logic              lr_set,
  input logic              sc_take
);
  AST_LR_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    lr_set && !cancel_act |=> resv_flag); // R2
  AST_BUS_DONE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start && bus_ready |=> rsp_valid && rsp_ok); // R3
  AST_FAIL_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    sc_take && !resv_flag |=> rsp_valid && !rsp_ok && !bus_start); // R4
  AST_SC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sc_take |=> !resv_flag); // R6
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_act |=> !resv_flag); // R8
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start || rsp_valid) |-> !req_ready); // R10
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start && !bus_ready |=> bus_start && $stable(bus_addr)); // R10
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ok)); // R10
  AST_QUAL_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
    bus_resv == bus_start); // R11
endmodule

bind resv_flag_ctrl resv_flag_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_ok(rsp_ok), .bus_start(bus_start),
  .bus_resv(bus_resv), .bus_ready(bus_ready), .bus_addr(bus_addr),
  .resv_flag(resv_flag), .cancel_act(cancel_act), .lr_set(lr_set),
  .sc_take(sc_take)
);

// File: tb/test_resv_flag_ctrl.sv
`timescale 1ns/100ps
module test_resv_flag_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cancel_n = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_kind = 1'b0;
  logic [29:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_ok;
  logic        bus_start;
  logic        bus_resv;
  logic        bus_ready = 1'b0;
  logic [29:0] bus_addr;
  logic [31:0] bus_wdata;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  resv_flag_ctrl i_resv_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .cancel_n(cancel_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ok(rsp_ok),
    .bus_start(bus_start), .bus_resv(bus_resv), .bus_ready(bus_ready),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata)
  );

  // {kind, expected ok, word address, data}; kind 0 load-reserve, 1 store-conditional
  localparam int NVEC = 12;
  localparam logic [63:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 30'h010, 32'h0000_0000},  // R1 R4 nothing held after reset
    {1'b0, 1'b1, 30'h010, 32'h0000_0000},  // R2
    {1'b1, 1'b1, 30'h010, 32'hA5A5_0001},  // R3
    {1'b1, 1'b0, 30'h010, 32'hA5A5_0002},  // R6 second store fails
    {1'b0, 1'b1, 30'h020, 32'h0000_0000},
    {1'b1, 1'b0, 30'h024, 32'hA5A5_0003},  // R5 address mismatch
    {1'b0, 1'b1, 30'h030, 32'h0000_0000},
    {1'b0, 1'b1, 30'h040, 32'h0000_0000},
    {1'b1, 1'b0, 30'h030, 32'hA5A5_0004},  // R9 old address fails
    {1'b0, 1'b1, 30'h030, 32'h0000_0000},
    {1'b0, 1'b1, 30'h3FF_FFFF, 32'h0000_0000},
    {1'b1, 1'b1, 30'h3FF_FFFF, 32'hDEAD_BEEF} // R9 newer address wins
  };

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_req(input logic kind, input logic [29:0] addr,
                        input logic [31:0] data, input logic exp_ok,
                        input int bus_wait, input int rsp_wait, input string req);
    rsp_ready = (rsp_wait == 0);
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_addr = addr; req_wdata = data;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (kind && exp_ok) begin
      chk(bus_start == 1'b1, req, "bus_start after store", 64'(bus_start), 64'd1);
      chk(bus_resv == 1'b1, "R11", "qualifier with strobe", 64'(bus_resv), 64'd1);
      chk(bus_addr == addr && bus_wdata == data, req, "bus addr/data",
          {2'b0, bus_addr, bus_wdata}, {2'b0, addr, data});
      chk(req_ready == 1'b0, "R10", "ready low while on bus", 64'(req_ready), 64'd0);
      for (int i = 0; i < bus_wait; i++) begin
        @(negedge clk);
        chk(bus_start && bus_resv && bus_addr == addr, "R10", "bus hold",
            64'(bus_start), 64'd1);
      end
      bus_ready = 1'b1;
      @(negedge clk);
      bus_ready = 1'b0;
    end else begin
      chk(bus_start == 1'b0, req, "no bus cycle", 64'(bus_start), 64'd0);
      chk(bus_resv == 1'b0, "R11", "qualifier idle", 64'(bus_resv), 64'd0);
    end
    chk(rsp_valid == 1'b1 && rsp_ok == exp_ok, req, "response ok",
        {62'd0, rsp_valid, rsp_ok}, {62'd0, 1'b1, exp_ok});
    for (int i = 0; i < rsp_wait; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_ok == exp_ok && !req_ready, "R10", "response hold",
          {62'd0, rsp_valid, rsp_ok}, {62'd0, 1'b1, exp_ok});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, req, "response consumed",
        {62'd0, rsp_valid, req_ready}, 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && bus_start == 1'b0 && bus_resv == 1'b0,
        "R1", "reset outputs", {60'd0, req_ready, rsp_valid, bus_start, bus_resv}, 64'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && bus_start == 1'b0,
        "R1", "idle after reset", {61'd0, req_ready, rsp_valid, bus_start}, 64'h4);

    for (int v = 0; v < NVEC; v++)
      do_req(VEC[v][63], VEC[v][61:32], VEC[v][31:0], VEC[v][62], 0, 0, "R3/R4/R5/R6/R9 vector");

    // R10 back-pressure on both bus and response sides
    do_req(1'b0, 30'h050, 32'h0, 1'b1, 0, 2, "R2");
    do_req(1'b1, 30'h050, 32'h1234_5678, 1'b1, 3, 3, "R10");

    // R7 cancel held low across several edges
    do_req(1'b0, 30'h060, 32'h0, 1'b1, 0, 0, "R2");
    @(negedge clk); cancel_n = 1'b0;
    repeat (3) @(negedge clk);
    cancel_n = 1'b1;
    do_req(1'b1, 30'h060, 32'h0, 1'b0, 0, 0, "R7");

    // R7 single-edge low pulse still clears
    do_req(1'b0, 30'h070, 32'h0, 1'b1, 0, 0, "R2");
    @(negedge clk); cancel_n = 1'b0;
    @(negedge clk); cancel_n = 1'b1;
    repeat (3) @(negedge clk);
    do_req(1'b1, 30'h070, 32'h0, 1'b0, 0, 0, "R7");

    // R8 cancel active in the very cycle the load-reserve is accepted
    do_req(1'b0, 30'h080, 32'h0, 1'b1, 0, 0, "R2");
    @(negedge clk); cancel_n = 1'b0;
    @(negedge clk); cancel_n = 1'b1;
    do_req(1'b0, 30'h090, 32'h0, 1'b1, 0, 0, "R8");
    do_req(1'b1, 30'h090, 32'h0, 1'b0, 0, 0, "R8");

    // cancel released well before: reservation works again
    repeat (3) @(negedge clk);
    do_req(1'b0, 30'h0A0, 32'h0, 1'b1, 0, 0, "R2");
    do_req(1'b1, 30'h0A0, 32'hCAFE_0000, 1'b1, 1, 0, "R3");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule